// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This block guards a single-port shared word memory that several requesters use to coordinate. Each requester raises a request carrying an operation code, a word address, a data word and a tested register value. It keeps the request up until the block accepts it. A single round-robin arbiter picks one requester, and the block then runs that requester's whole read-modify-write as one indivisible sequence. No other requester is accepted until the write phase is over and the response has gone out.

The block offers four operation codes. Test-and-set claims a lock word that reads zero. Conditional exchange swaps a word in only when the requester's tested register is zero. Load-reserve and store-conditional form a pair: software can place any number of other operations between the load and the store. The block keeps one reservation entry per requester. A successful write to a reserved address by a different requester removes that reservation. A store-conditional always drops the issuer's own reservation.

The sequence controller is a five-state machine:
- S_IDLE: arbitrate and accept a request.
- S_READ: read the addressed word.
- S_EVAL: decide whether to write, and what to report.
- S_COMMIT: the write phase. It writes the memory when the decision allows and updates the reservations.
- S_RESP: present the response to the owner for one cycle.

The transitions are:
- S_IDLE to S_READ when any request is valid.
- S_READ to S_EVAL, S_EVAL to S_COMMIT, S_COMMIT to S_RESP and S_RESP to S_IDLE, each unconditionally.

Top module: `amo_unit`

## Requirements
- R1: Test-and-set (opcode 0) on a word that reads zero writes the request data word and responds with data 0 and ok=1.
- R2: Test-and-set on a nonzero word leaves memory unchanged and responds with the old nonzero word and ok=0.
- R3: Conditional exchange (opcode 1) with a zero tested value writes the request data word and responds with the old word and ok=1. With a nonzero tested value, memory is unchanged and the response carries the old word with ok=0.
- R4: Load-reserve (opcode 2) responds with the addressed word and ok=1, and records a valid reservation on that address for the issuer.
- R5: Store-conditional (opcode 3) writes the data word and responds with ok=1 only when the issuer holds a valid reservation on the same address. Otherwise it writes nothing and responds with ok=0. In both cases the response data is the word read.
- R6: A reservation survives any number of intervening operations that do not write its address, including reads of that address by others.
- R7: A successful write by a different requester to a reserved address clears that reservation. A failed test-and-set to that address does not clear it.
- R8: Every store-conditional clears its issuer's reservation, whether it succeeds or fails.
- R9: At most one requester is accepted per cycle, and only a requester with a valid request. No request is accepted from the accept cycle until the response cycle has passed.
- R10: With several requesters waiting, grants rotate round-robin, starting with the requester after the one granted last.
- R11: The response appears exactly 4 cycles after the accept cycle, as a one-cycle pulse on the owner's rsp_valid bit.
- R12: After reset, no response is pending, every reservation is clear and every memory word reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | N | Request present, one bit per requester |
| req_ready | output | N | Request accepted this cycle, one-hot or zero |
| req_op | input | N x 2 | Operation code per requester (0 set, 1 exchange, 2 load-reserve, 3 store-conditional) |
| req_addr | input | N x AW | Word address per requester |
| req_wdata | input | N x DW | Data word to write per requester |
| req_cmp | input | N x DW | Tested register value per requester (exchange only) |
| rsp_valid | output | N | Response pulse for the owning requester |
| rsp_data | output | DW | Word read by the operation |
| rsp_ok | output | 1 | Success flag of the operation |

## Verification
The checker assumes two things about requesters. Each one holds its request steady until it sees its ready bit. Requests that arrive while the block is busy simply wait. The stimulus meets both assumptions: each requester drives its fields and its valid bit at a falling edge, and drops them only one falling edge after its ready was seen. Several requesters contend only in the round-robin phase, where the block itself orders them and every address used is distinct.

// File: rtl/amo_pkg.sv
package amo_pkg;

    typedef enum logic [1:0] {
        OP_TAS  = 2'd0,
        OP_XCHG = 2'd1,
        OP_LR   = 2'd2,
        OP_SC   = 2'd3
    } amo_op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_READ,
        S_EVAL,
        S_COMMIT,
        S_RESP
    } amo_state_e;

endpackage

// File: rtl/amo_rr_arb.sv
module amo_rr_arb #(
    parameter int N   = 4,
    parameter int IDW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   req,
    input  logic           advance,
    output logic [N-1:0]   grant,
    output logic [IDW-1:0] grant_id
);

    logic [IDW-1:0] last_q;
    logic           found;

    // search starts one past the last winner and wraps
    always_comb begin
        grant    = '0;
        grant_id = '0;
        found    = 1'b0;
        for (int k = 1; k <= N; k++) begin
            int idx;
            idx = int'(last_q) + k;
            if (idx >= N) idx = idx - N;
            if (!found && req[idx]) begin
                found      = 1'b1;
                grant[idx] = 1'b1;
                grant_id   = IDW'(idx);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       last_q <= IDW'(N - 1);
        else if (advance) last_q <= grant_id;
    end

endmodule

// File: rtl/amo_resv_tbl.sv
module amo_resv_tbl #(
    parameter int N   = 4,
    parameter int AW  = 4,
    parameter int IDW = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  set_en,
    input  logic                  clr_own_en,
    input  logic                  wr_en,
    input  logic [IDW-1:0]        own_id,
    input  logic [AW-1:0]         addr,
    output logic [N-1:0]          rv,
    output logic [N-1:0][AW-1:0]  ra
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rv <= '0;
            ra <= '0;
        end else begin
            for (int g = 0; g < N; g++) begin
                if (IDW'(g) == own_id) begin
                    if (set_en) begin
                        rv[g] <= 1'b1;
                        ra[g] <= addr;
                    end else if (clr_own_en) begin
                        rv[g] <= 1'b0;
                    end
                end else if (wr_en && rv[g] && (ra[g] == addr)) begin
                    rv[g] <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/amo_sram.sv
module amo_sram #(
    parameter int DW = 32,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          re,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
            rdata <= '0;
        end else begin
            if (we) mem_q[addr] <= wdata;
            if (re) rdata <= mem_q[addr];
        end
    end

endmodule

// File: rtl/amo_unit.sv
module amo_unit
    import amo_pkg::*;
#(
    parameter int N  = 4,
    parameter int DW = 32,
    parameter int AW = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N-1:0]          req_valid,
    output logic [N-1:0]          req_ready,
    input  logic [N-1:0][1:0]     req_op,
    input  logic [N-1:0][AW-1:0]  req_addr,
    input  logic [N-1:0][DW-1:0]  req_wdata,
    input  logic [N-1:0][DW-1:0]  req_cmp,
    output logic [N-1:0]          rsp_valid,
    output logic [DW-1:0]         rsp_data,
    output logic                  rsp_ok
);

    localparam int IDW = (N > 1) ? $clog2(N) : 1;

    amo_state_e     state_q, state_d;
    logic [N-1:0]   grant;
    logic [IDW-1:0] grant_id;
    logic           accept;
    logic           busy;

    logic [IDW-1:0] own_q;
    amo_op_e        op_q;
    logic [AW-1:0]  addr_q;
    logic [DW-1:0]  wdata_q;
    logic [DW-1:0]  cmp_q;
    logic [DW-1:0]  result_q;
    logic           ok_q;
    logic           dowr_q;

    logic [DW-1:0]  mem_rdata;
    logic           mem_re;
    logic           mem_we;

    logic [N-1:0]         rv;
    logic [N-1:0][AW-1:0] ra;
    logic           resv_set;
    logic           resv_clr;
    logic           ev_wr;
    logic           ev_ok;
    logic           sc_hit;

    assign accept = (state_q == S_IDLE) && (|req_valid);

    amo_rr_arb #(.N(N), .IDW(IDW)) u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req_valid),
        .advance  (accept),
        .grant    (grant),
        .grant_id (grant_id)
    );

    amo_sram #(.DW(DW), .AW(AW)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .re    (mem_re),
        .we    (mem_we),
        .addr  (addr_q),
        .wdata (wdata_q),
        .rdata (mem_rdata)
    );

    amo_resv_tbl #(.N(N), .AW(AW), .IDW(IDW)) u_resv (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_en     (resv_set),
        .clr_own_en (resv_clr),
        .wr_en      (mem_we),
        .own_id     (own_q),
        .addr       (addr_q),
        .rv         (rv),
        .ra         (ra)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (accept) state_d = S_READ;
            S_READ:   state_d = S_EVAL;
            S_EVAL:   state_d = S_COMMIT;
            S_COMMIT: state_d = S_RESP;
            S_RESP:   state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // operation decision on the word just read
    assign sc_hit = rv[own_q] && (ra[own_q] == addr_q);

    always_comb begin
        ev_wr = 1'b0;
        ev_ok = 1'b0;
        unique case (op_q)
            OP_TAS: begin
                ev_wr = (mem_rdata == '0);
                ev_ok = ev_wr;
            end
            OP_XCHG: begin
                ev_wr = (cmp_q == '0);
                ev_ok = ev_wr;
            end
            OP_LR: begin
                ev_wr = 1'b0;
                ev_ok = 1'b1;
            end
            OP_SC: begin
                ev_wr = sc_hit;
                ev_ok = sc_hit;
            end
            default: begin
                ev_wr = 1'b0;
                ev_ok = 1'b0;
            end
        endcase
    end

    // request capture and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            own_q    <= '0;
            op_q     <= OP_TAS;
            addr_q   <= '0;
            wdata_q  <= '0;
            cmp_q    <= '0;
            result_q <= '0;
            ok_q     <= 1'b0;
            dowr_q   <= 1'b0;
        end else begin
            if (accept) begin
                own_q   <= grant_id;
                op_q    <= amo_op_e'(req_op[grant_id]);
                addr_q  <= req_addr[grant_id];
                wdata_q <= req_wdata[grant_id];
                cmp_q   <= req_cmp[grant_id];
            end
            if (state_q == S_EVAL) begin
                result_q <= mem_rdata;
                ok_q     <= ev_ok;
                dowr_q   <= ev_wr;
            end
        end
    end

    // outputs
    always_comb begin
        req_ready = '0;
        rsp_valid = '0;
        mem_re    = 1'b0;
        mem_we    = 1'b0;
        resv_set  = 1'b0;
        resv_clr  = 1'b0;
        busy      = 1'b1;
        unique case (state_q)
            S_IDLE: begin
                busy      = 1'b0;
                req_ready = grant;
            end
            S_READ:   mem_re = 1'b1;
            S_EVAL:   ;
            S_COMMIT: begin
                mem_we   = dowr_q;
                resv_set = (op_q == OP_LR);
                resv_clr = (op_q == OP_SC);
            end
            S_RESP: begin
                for (int i = 0; i < N; i++)
                    rsp_valid[i] = (own_q == IDW'(i));
            end
            default: busy = 1'b1;
        endcase
    end

    assign rsp_data = result_q;
    assign rsp_ok   = ok_q;

endmodule

// File: rtl/amo_unit_checker.sv
module amo_unit_checker #(
    parameter int N = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] req_valid,
    input logic [N-1:0] req_ready,
    input logic [N-1:0] rsp_valid,
    input logic         mem_re,
    input logic         mem_we,
    input logic         busy
);

    assert_one_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_ready));

    assert_grant_needs_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready & ~req_valid) == '0);

    assert_locked_while_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (req_ready == '0));

    assert_read_follows_grant_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_ready) |=> mem_re);

    assert_resp_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_ready) |-> ##4 (|rsp_valid));

    assert_one_response_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rsp_valid));

    assert_single_port_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_re && mem_we));

    assert_no_grant_on_resp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|rsp_valid) |-> (req_ready == '0));

endmodule

bind amo_unit amo_unit_checker #(.N(N)) u_amo_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .mem_re    (mem_re),
    .mem_we    (mem_we),
    .busy      (busy)
);

// File: tb/test_amo_unit.sv
`timescale 1ns/1ps
module test_amo_unit;

    localparam int N  = 4;
    localparam int DW = 32;
    localparam int AW = 4;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [N-1:0]         req_valid = '0;
    logic [N-1:0]         req_ready;
    logic [N-1:0][1:0]    req_op = '0;
    logic [N-1:0][AW-1:0] req_addr = '0;
    logic [N-1:0][DW-1:0] req_wdata = '0;
    logic [N-1:0][DW-1:0] req_cmp = '0;
    logic [N-1:0]         rsp_valid;
    logic [DW-1:0]        rsp_data;
    logic                 rsp_ok;

    amo_unit #(.N(N), .DW(DW), .AW(AW)) i_amo_unit (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_cmp(req_cmp),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_ok(rsp_ok)
    );

    always #4 clk = ~clk;

    typedef struct {
        int          id;
        logic [31:0] data;
        logic        ok;
        string       tag;
    } exp_t;

    exp_t        sb_q[$];
    int          n_checks = 0;
    int          n_errors = 0;
    int          cyc = 0;
    int          acc_cyc = 0;
    bit          outstanding = 0;

    logic [31:0] tb_mem [16];
    bit          tb_rv [N];
    int          tb_ra [N];

    always @(posedge clk) cyc++;

    // expected result from the requirements, updating the model
    task automatic predict(int id, int op, int addr, logic [31:0] wd,
                           logic [31:0] cmp, string tag);
        exp_t e;
        logic [31:0] old;
        bit ok, wr;
        old = tb_mem[addr];
        ok = 0; wr = 0;
        case (op)
            0: begin ok = (old == 0); wr = ok; end
            1: begin ok = (cmp == 0); wr = ok; end
            2: begin ok = 1; tb_rv[id] = 1; tb_ra[id] = addr; end
            default: begin
                ok = tb_rv[id] && (tb_ra[id] == addr);
                wr = ok;
                tb_rv[id] = 0;
            end
        endcase
        if (wr) begin
            tb_mem[addr] = wd;
            for (int j = 0; j < N; j++)
                if (j != id && tb_rv[j] && tb_ra[j] == addr) tb_rv[j] = 0;
        end
        e.id = id; e.data = old; e.ok = ok; e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic drive(int id, int op, int addr, logic [31:0] wd, logic [31:0] cmp);
        @(negedge clk);
        req_op[id]    = 2'(op);
        req_addr[id]  = AW'(addr);
        req_wdata[id] = wd;
        req_cmp[id]   = cmp;
        req_valid[id] = 1'b1;
        #1;
        while (!req_ready[id]) @(negedge clk);
        n_checks++;
        if (outstanding) begin
            n_errors++;
            $display("FAIL R9: accept while busy, actual outstanding=1 expected 0");
        end
        outstanding = 1;
        acc_cyc = cyc;
        @(negedge clk);
        req_valid[id] = 1'b0;
    endtask

    task automatic run_op(int id, int op, int addr, logic [31:0] wd,
                          logic [31:0] cmp, string tag);
        predict(id, op, addr, wd, cmp, tag);
        drive(id, op, addr, wd, cmp);
        wait (outstanding == 0);
        @(negedge clk);
    endtask

    // monitor: compares each response against the scoreboard head
    always @(negedge clk) begin
        if (rst_n && (|rsp_valid)) begin
            exp_t e;
            int got_id;
            got_id = -1;
            for (int i = 0; i < N; i++) if (rsp_valid[i]) got_id = i;
            n_checks++;
            if (sb_q.size() == 0) begin
                n_errors++;
                $display("FAIL R11: unexpected response from %0d, expected none", got_id);
            end else begin
                e = sb_q.pop_front();
                if (got_id != e.id || rsp_data !== e.data || rsp_ok !== e.ok) begin
                    n_errors++;
                    $display("FAIL %s: actual id=%0d data=%h ok=%b expected id=%0d data=%h ok=%b",
                             e.tag, got_id, rsp_data, rsp_ok, e.id, e.data, e.ok);
                end
            end
            n_checks++;
            if (cyc - acc_cyc != 4) begin
                n_errors++;
                $display("FAIL R11: latency actual %0d expected 4", cyc - acc_cyc);
            end
            outstanding = 0;
        end
    end

    initial begin
        #(8 * 20000);
        n_errors++;
        $display("FAIL watchdog: actual hung expected completion");
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) tb_mem[i] = 0;
        for (int i = 0; i < N; i++) begin tb_rv[i] = 0; tb_ra[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        n_checks++;
        if (rsp_valid !== '0 || req_ready !== '0) begin
            n_errors++;
            $display("FAIL R12: actual rsp_valid=%b ready=%b expected 0 0", rsp_valid, req_ready);
        end
        run_op(2, 2, 2, 0, 0, "R12");          // memory reads zero after reset
        run_op(2, 3, 6, 32'h11, 0, "R12");     // reservation elsewhere: fails

        run_op(0, 0, 3, 32'hA5, 0, "R1");
        run_op(1, 0, 3, 32'h77, 0, "R2");
        run_op(2, 2, 3, 0, 0, "R2");           // word still A5

        run_op(2, 1, 5, 32'h1234, 0, "R3");
        run_op(3, 1, 5, 32'h55, 32'd9, "R3");
        run_op(0, 2, 5, 0, 0, "R3");

        run_op(1, 2, 7, 0, 0, "R4");
        run_op(1, 3, 7, 32'hBEEF, 0, "R5");
        run_op(3, 2, 7, 0, 0, "R5");
        run_op(0, 3, 8, 32'h42, 0, "R5");      // reserved 5, stores 8: fail
        run_op(3, 2, 8, 0, 0, "R5");           // 8 untouched

        run_op(2, 2, 9, 0, 0, "R6");
        run_op(0, 0, 10, 32'h3, 0, "R6");
        run_op(3, 1, 11, 32'h4, 0, "R6");
        run_op(1, 2, 9, 0, 0, "R6");
        run_op(2, 3, 9, 32'h99, 0, "R6");

        run_op(3, 2, 12, 0, 0, "R7");
        run_op(1, 0, 12, 32'h5, 0, "R7");
        run_op(3, 3, 12, 32'h8, 0, "R7");
        run_op(0, 2, 12, 0, 0, "R7");
        run_op(2, 0, 12, 32'h6, 0, "R7");      // failed set keeps reservation
        run_op(0, 3, 12, 32'h6, 0, "R7");

        run_op(1, 2, 13, 0, 0, "R8");
        run_op(1, 3, 13, 32'hC, 0, "R8");
        run_op(1, 3, 13, 32'hD, 0, "R8");
        run_op(2, 2, 14, 0, 0, "R8");
        run_op(2, 3, 15, 32'hE, 0, "R8");
        run_op(2, 3, 14, 32'hF, 0, "R8");

        // round robin: last winner is 1, so order 2,3,0,1
        run_op(1, 2, 0, 0, 0, "R10");
        predict(2, 2, 2, 0, 0, "R10");
        predict(3, 2, 3, 0, 0, "R10");
        predict(0, 2, 4, 0, 0, "R10");
        predict(1, 2, 5, 0, 0, "R10");
        fork
            drive(0, 2, 4, 0, 0);
            drive(1, 2, 5, 0, 0);
            drive(2, 2, 2, 0, 0);
            drive(3, 2, 3, 0, 0);
        join
        wait (outstanding == 0);
        repeat (2) @(negedge clk);
        n_checks++;
        if (sb_q.size() != 0) begin
            n_errors++;
            $display("FAIL R10: actual %0d responses missing expected 0", sb_q.size());
        end
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule